// File: doc/BRIEF.md
# Cipher Subkey Expansion Unit

This block expands a 128-bit user key into the 52 sixteen-bit subkeys used by a 64-bit block cipher. The cipher has eight rounds of six subkeys each, followed by an output transformation that takes four more. A working register holds the key. On each pass the register is read as eight 16-bit words, from the most significant word down, and each word becomes the next subkey. At the end of the pass the register is rotated left by 25 bits. The sequence stops after the 52nd subkey, which falls partway through the seventh pass.

A one-cycle start pulse loads the key. From the next cycle the block emits one subkey per clock, with a valid strobe and a 6-bit index. Each subkey is also written into an internal register file, which can be read at any time by index through a combinational read port. When the last subkey has been written, the block raises a done flag and holds it.

Top module: `subkey_expander`

## Requirements
- R1: After reset, `sk_valid` and `done` are 0, `sk_index` is 0, and every register-file entry reads as 0.
- R2: Subkeys 0 to 7 are the loaded key's 16-bit words in order from bits 127:112 down to bits 15:0. Subkey 0 appears in the cycle after the start pulse.
- R3: Subkey 8g+w (w = 0..7) is word w, counted from the most significant end, of the key rotated left by 25·g bits. Rotation happens only between groups of eight.
- R4: Exactly 52 consecutive valid cycles follow a start. The last has index 51, and `sk_valid` is 0 in the cycle after it. The bottom four words of the seventh pass are never emitted.
- R5: `done` rises in the cycle after index 51 is emitted. It stays high until the next start, and `sk_valid` and `done` are never high together.
- R6: A start pulse while subkeys are still being emitted abandons the current sequence. The next cycle restarts at index 0 from the new key.
- R7: `rd_word` returns the subkey stored at `rd_idx` for indices 0 to 51, and 0 for indices 52 to 63.
- R8: While valid, `sk_index` increases by exactly one per clock, starting at 0.
- R9: When no start and no emission is in progress, the working key register does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | One-cycle pulse that loads `key_in` and starts the expansion |
| key_in | input | 128 | User key, sampled when `start` is high |
| sk_valid | output | 1 | A subkey is present on `sk_word` |
| sk_index | output | 6 | Index of the current subkey (0 to 51) |
| sk_word | output | 16 | Current subkey |
| done | output | 1 | All 52 subkeys are stored |
| rd_idx | input | 6 | Register-file read index |
| rd_word | output | 16 | Stored subkey at `rd_idx`, or 0 when the index is out of range |

## Verification
The assertions check the sequencing on every cycle: the index stepping by one, the stop after index 51, done rising and holding, restart on a start pulse, valid and done never overlapping, and the working register holding still when idle. Only the bench scenarios can show that the subkey values are correct. It compares every streamed word and every register-file entry with a model of the 25-bit rotation, for several keys, and it covers a restart in mid-sequence and the out-of-range reads.

// File: rtl/skx_pkg.sv
package skx_pkg;
  localparam int KEY_W  = 128;
  localparam int WORD_W = 16;
  localparam int NUM_SK = 52;
  localparam int ROT    = 25;
  localparam int WPP    = KEY_W / WORD_W;      // words per pass
  localparam int IDX_W  = $clog2(NUM_SK);
  localparam int SEL_W  = $clog2(WPP);
endpackage

// File: rtl/skx_ctrl.sv
module skx_ctrl
  import skx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             rot_en,
  output logic             done
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             busy_q, busy_d, done_q, done_d;
  logic             last;

  assign last   = (idx_q == IDX_W'(NUM_SK - 1));
  assign rot_en = busy_q && (idx_q[SEL_W-1:0] == SEL_W'(WPP - 1));

  always_comb begin
    idx_d  = idx_q;
    busy_d = busy_q;
    done_d = done_q;
    if (start) begin
      idx_d  = '0;
      busy_d = 1'b1;
      done_d = 1'b0;
    end else if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign idx  = busy_q ? idx_q : '0;
  assign done = done_q;

  a_r8_index_step: assert property (@(posedge clk) disable iff (!rst_ni)
    busy && !start && !last |=> busy && idx == $past(idx) + IDX_W'(1));
  a_r4_stop_after_last: assert property (@(posedge clk) disable iff (!rst_ni)
    busy && !start && last |=> !busy && done);
  a_r5_done_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    done && !start |=> done);
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_ni)
    !(busy && done));
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_ni)
    start |=> busy && idx == '0 && !done);
endmodule

// File: rtl/skx_shift.sv
module skx_shift
  import skx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load,
  input  logic [KEY_W-1:0]  key,
  input  logic              rot_en,
  input  logic [SEL_W-1:0]  sel,
  output logic [WORD_W-1:0] word
);
  logic [KEY_W-1:0] work_q, work_d;
  logic             en;

  assign en = load | rot_en;

  always_comb begin
    if (load) work_d = key;
    else      work_d = {work_q[KEY_W-ROT-1:0], work_q[KEY_W-1:KEY_W-ROT]};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  work_q <= '0;
    else if (en)  work_q <= work_d;
  end

  // word 0 is the most significant
  always_comb begin
    word = '0;
    for (int w = 0; w < WPP; w++)
      if (sel == SEL_W'(w)) word = work_q[KEY_W-1-w*WORD_W -: WORD_W];
  end

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !load && !rot_en |=> $stable(work_q));
  a_r2_load_top_word: assert property (@(posedge clk) disable iff (!rst_ni)
    load |=> work_q[KEY_W-1 -: WORD_W] == $past(key[KEY_W-1 -: WORD_W]));
endmodule

// File: rtl/skx_store.sv
module skx_store
  import skx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem [NUM_SK];

  for (genvar e = 0; e < NUM_SK; e++) begin : g_ent
    logic hit;
    assign hit = we && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)  mem[e] <= '0;
      else if (hit) mem[e] <= wr_word;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int e = 0; e < NUM_SK; e++)
      if (rd_idx == IDX_W'(e)) rd_word = mem[e];
  end

  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_ni)
    we && rd_idx == wr_idx |=> rd_idx != $past(rd_idx) || rd_word == $past(wr_word));
endmodule

// File: rtl/subkey_expander.sv
module subkey_expander
  import skx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [KEY_W-1:0]  key_in,
  output logic              sk_valid,
  output logic [IDX_W-1:0]  sk_index,
  output logic [WORD_W-1:0] sk_word,
  output logic              done,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  logic       rot_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  skx_ctrl u_ctrl (
    .clk(clk), .rst_ni(rst_ni), .start(start),
    .busy(sk_valid), .idx(sk_index), .rot_en(rot_en), .done(done)
  );

  skx_shift u_shift (
    .clk(clk), .rst_ni(rst_ni), .load(start), .key(key_in),
    .rot_en(rot_en && !start), .sel(sk_index[SEL_W-1:0]), .word(sk_word)
  );

  skx_store u_store (
    .clk(clk), .rst_ni(rst_ni), .we(sk_valid && !start),
    .wr_idx(sk_index), .wr_word(sk_word),
    .rd_idx(rd_idx), .rd_word(rd_word)
  );

  a_r1_idle_outputs: assert property (@(posedge clk) disable iff (!rst_ni)
    !sk_valid |-> sk_index == '0);
endmodule

// File: tb/tb_subkey_expander.sv
module tb_subkey_expander;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] key_in = '0;
  logic         sk_valid, done;
  logic [5:0]   sk_index;
  logic [15:0]  sk_word, rd_word;
  logic [5:0]   rd_idx = '0;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  subkey_expander dut (
    .clk(clk), .rst_n(rst_n), .start(start), .key_in(key_in),
    .sk_valid(sk_valid), .sk_index(sk_index), .sk_word(sk_word),
    .done(done), .rd_idx(rd_idx), .rd_word(rd_word)
  );

  function automatic logic [15:0] exp_sk(input logic [127:0] k, input int i);
    logic [127:0] r;
    r = k;
    for (int g = 0; g < i / 8; g++) r = {r[102:0], r[127:103]};
    return r[127 - 16 * (i % 8) -: 16];
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [127:0] k);
    @(negedge clk);
    start = 1'b1; key_in = k;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic stream_and_file(input logic [127:0] k);
    for (int i = 0; i < 52; i++) begin
      check("R4 valid", sk_valid, 1);
      check("R8 index", sk_index, i);
      check(i < 8 ? "R2 word" : "R3 word", sk_word, exp_sk(k, i));
      check("R5 no done while valid", done, 0);
      @(negedge clk);
    end
    check("R4 stop after 51", sk_valid, 0);
    check("R5 done", done, 1);
    repeat (3) @(negedge clk);
    check("R5 done held", done, 1);
    check("R4 still idle", sk_valid, 0);
    for (int a = 0; a < 64; a++) begin
      rd_idx = 6'(a);
      #1;
      check("R7 file", rd_word, a < 52 ? 128'(exp_sk(k, a)) : 128'd0);
    end
  endtask

  initial begin
    logic [127:0] keys [5];
    keys[0] = 128'h0001_0002_0003_0004_0005_0006_0007_0008;
    keys[1] = '0;
    keys[2] = '1;
    keys[3] = 128'hA5A5_5A5A_F00F_0FF0_1234_5678_9ABC_DEF0;
    keys[4] = 128'h8000_0000_0000_0000_0000_0000_0000_0001;
    repeat (3) @(negedge clk);
    check("R1 valid", sk_valid, 0);
    check("R1 done", done, 0);
    check("R1 index", sk_index, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 valid after release", sk_valid, 0);
    for (int a = 0; a < 64; a += 7) begin
      rd_idx = 6'(a);
      #1;
      check("R1 file clear", rd_word, 0);
    end
    for (int n = 0; n < 5; n++) begin
      pulse_start(keys[n]);
      check("R5 done cleared by start", done, 0);
      stream_and_file(keys[n]);
    end
    // restart in mid-sequence
    pulse_start(keys[3]);
    repeat (10) @(negedge clk);
    check("R6 mid-run index", sk_index, 10);
    pulse_start(keys[0]);
    check("R6 restart index", sk_index, 0);
    stream_and_file(keys[0]);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule